// File: doc/BRIEF.md
# Timed Serial Word Transmitter

This block is a transmit-only serial master. It shifts one fixed-width word out on a single data line, framed by an active-low select and a generated serial clock. All timing comes from counting ticks of the system clock. The defaults assume 40 MHz, which gives a 1 µs select setup, a 2 µs bit period with a 1 µs high phase (500 kHz at 50% duty), and a 5 µs minimum gap between frames.

Words enter through a valid/ready handshake. The word is taken on a clock edge where both `in_valid` and `in_ready` are high. `in_ready` is high only when the transmitter is idle. It drops on the cycle after acceptance and stays low through the whole frame and the idle gap after it. A producer that holds `in_valid` high while `in_ready` is low is stalled, and the word it presents is not sampled. `busy` is the plain status inverse of `in_ready`.

Internally the sequencer walks through five states: idle, select setup, clock low, clock high and select release. A bit counter decides when the last bit has gone out.

Top module: `spi_word_tx`

## Requirements
- R1: A synchronous active-high `rst` forces `cs_n`=1, `sclk`=0, `mosi`=0, `in_ready`=1 and `busy`=0 on the next edge, including in the middle of a frame.
- R2: A word is accepted only on an edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 only while idle, and `busy` is always its inverse.
- R3: From the cycle after acceptance, `cs_n` is 0 with `sclk`=0 and `mosi`=0 for exactly SETUP_TICKS cycles before the first bit is presented.
- R4: Exactly WORD_BITS bits are sent, most significant first. `mosi` holds bit `in_word[WORD_BITS-1-b]` for the whole 2*HALF_TICKS-cycle period of bit b.
- R5: Each bit period is HALF_TICKS cycles of `sclk`=0 followed by HALF_TICKS cycles of `sclk`=1. `mosi` changes only while `sclk` is 0.
- R6: After the last bit, `cs_n`=1, `sclk`=0 and `mosi`=0 are held for GAP_TICKS cycles with `busy`=1 before `in_ready` returns. With `in_valid` held high, the next frame's select falls GAP_TICKS+1 cycles after release.
- R7: `in_valid` asserted while `in_ready` is 0 has no effect. The running frame continues unchanged, and no new frame starts after it unless `in_valid` is high while idle.
- R8: `sclk` is never 1 while `cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Transmitter idle, word will be taken |
| in_word | input | WORD_BITS | Word to send, MSB first |
| busy | output | 1 | Frame or idle gap in progress |
| cs_n | output | 1 | Active-low select |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data, idles low |

## Verification
The bench builds the block with WORD_BITS=4, SETUP_TICKS=3, HALF_TICKS=2 and GAP_TICKS=5, so one frame lasts 24 cycles. Because frames are this short, every one of the 16 possible words can be sent. Each output is then compared against a position-in-frame model on every cycle, which covers every bit value at every bit position. The same short frames also make it cheap to test stalled offers during a frame, back-to-back frames with `in_valid` held high, and a reset in mid-frame.

// File: rtl/spitx_pkg.sv
package spitx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CS_SETUP,
    ST_CLK_LO,
    ST_CLK_HI,
    ST_CS_RELEASE
  } spitx_state_e;
endpackage

// File: rtl/spitx_ticker.sv
// Down-counting interval timer: loaded with N-1, expired while at zero.
module spitx_ticker #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  p_count_settles_r5: assert property (@(posedge clk) disable iff (rst)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/spitx_shreg.sv
// Left-shifting word register presenting its top bit.
module spitx_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  output logic         top_bit
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)        sr_q <= '0;
    else if (load)  sr_q <= load_word;
    else if (shift) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign top_bit = sr_q[W-1];

  p_shift_moves_r4: assert property (@(posedge clk) disable iff (rst)
    (shift && !load) |=> (sr_q[W-1] == $past(sr_q[W-2])));
endmodule

// File: rtl/spi_word_tx.sv
module spi_word_tx
  import spitx_pkg::*;
#(
  parameter int WORD_BITS   = 16,
  parameter int SETUP_TICKS = 40,
  parameter int HALF_TICKS  = 40,
  parameter int GAP_TICKS   = 200
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [WORD_BITS-1:0] in_word,
  output logic                 busy,
  output logic                 cs_n,
  output logic                 sclk,
  output logic                 mosi
);
  localparam int MAX_A = (SETUP_TICKS > HALF_TICKS) ? SETUP_TICKS : HALF_TICKS;
  localparam int MAX_T = (MAX_A > GAP_TICKS) ? MAX_A : GAP_TICKS;
  localparam int CW    = $clog2(MAX_T + 1);
  localparam int BW    = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_TICKS - 1);
  localparam logic [CW-1:0] HALF_LD  = CW'(HALF_TICKS - 1);
  localparam logic [CW-1:0] GAP_LD   = CW'(GAP_TICKS - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(WORD_BITS - 1);

  spitx_state_e  state_q, state_d;
  logic [BW-1:0] bit_q;
  logic          tmr_load, tmr_expired;
  logic [CW-1:0] tmr_val;
  logic          sh_load, sh_shift, sh_top;
  logic          bit_clr, bit_inc;
  logic          framing;

  spitx_ticker #(.CW(CW)) u_ticker (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  spitx_shreg #(.W(WORD_BITS)) u_shreg (
    .clk       (clk),
    .rst       (rst),
    .load      (sh_load),
    .load_word (in_word),
    .shift     (sh_shift),
    .top_bit   (sh_top)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    bit_clr  = 1'b0;
    bit_inc  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (in_valid) begin
        state_d  = ST_CS_SETUP;
        tmr_load = 1'b1;
        tmr_val  = SETUP_LD;
        sh_load  = 1'b1;
      end
      ST_CS_SETUP: if (tmr_expired) begin
        state_d  = ST_CLK_LO;
        tmr_load = 1'b1;
        tmr_val  = HALF_LD;
        bit_clr  = 1'b1;
      end
      ST_CLK_LO: if (tmr_expired) begin
        state_d  = ST_CLK_HI;
        tmr_load = 1'b1;
        tmr_val  = HALF_LD;
      end
      ST_CLK_HI: if (tmr_expired) begin
        tmr_load = 1'b1;
        if (bit_q == LAST_BIT) begin
          state_d = ST_CS_RELEASE;
          tmr_val = GAP_LD;
        end else begin
          state_d  = ST_CLK_LO;
          tmr_val  = HALF_LD;
          sh_shift = 1'b1;
          bit_inc  = 1'b1;
        end
      end
      ST_CS_RELEASE: if (tmr_expired) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      if (bit_clr)      bit_q <= '0;
      else if (bit_inc) bit_q <= bit_q + 1'b1;
    end
  end

  assign framing  = (state_q == ST_CLK_LO) || (state_q == ST_CLK_HI);
  assign in_ready = (state_q == ST_IDLE);
  assign busy     = !in_ready;
  assign cs_n     = !(framing || state_q == ST_CS_SETUP);
  assign sclk     = (state_q == ST_CLK_HI);
  assign mosi     = framing && sh_top;

  p_sclk_needs_cs_r8: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !cs_n);
  p_mosi_still_hi_r5: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi));
  p_ready_idle_lines_r2: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (cs_n && !sclk && !mosi));
  p_cs_fall_on_accept_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(in_valid && in_ready));
  p_gap_lines_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CS_RELEASE) |-> (cs_n && !sclk && !mosi && busy));
  p_stall_no_effect_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && state_q != ST_CS_RELEASE) |=> !in_ready);
endmodule

// File: tb/sim_spi_word_tx.sv
module sim_spi_word_tx;
  localparam int W = 4;
  localparam int S = 3;
  localparam int H = 2;
  localparam int G = 5;
  localparam int TOTAL = S + 2 * H * W + G;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_word = '0;
  logic         in_ready, busy, cs_n, sclk, mosi;
  int           vectors = 0;
  int           errs = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  spi_word_tx #(.WORD_BITS(W), .SETUP_TICKS(S), .HALF_TICKS(H), .GAP_TICKS(G)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .busy(busy), .cs_n(cs_n), .sclk(sclk), .mosi(mosi)
  );

  task automatic cmp(string rq, logic [4:0] act, logic [4:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: {cs_n,sclk,mosi,ready,busy} actual %b expected %b at %0t",
               rq, act, exp, $time);
    end
  endtask

  task automatic expect_idle(string rq);
    cmp(rq, {cs_n, sclk, mosi, in_ready, busy}, 5'b10010);
  endtask

  // Expected lines at frame position t (t=0 is the first cycle after acceptance).
  task automatic expect_at(logic [W-1:0] w, int t);
    logic [4:0] e;
    string rq;
    if (t < S) begin
      e = 5'b00001; rq = "R3";
    end else if (t < S + 2 * H * W) begin
      int b  = (t - S) / (2 * H);
      int ph = (t - S) % (2 * H);
      e = {1'b0, (ph >= H), w[W-1-b], 1'b0, 1'b1}; rq = "R4/R5";
    end else if (t < TOTAL) begin
      e = 5'b10001; rq = "R6";
    end else begin
      e = 5'b10010; rq = "R2/R6";
    end
    cmp(rq, {cs_n, sclk, mosi, in_ready, busy}, e);
  endtask

  // Called at a negedge while idle; returns at the negedge of position TOTAL.
  task automatic frame(logic [W-1:0] w, bit inject, bit hold);
    in_valid = 1'b1;
    in_word  = w;
    @(posedge clk);
    for (int t = 0; t <= TOTAL; t++) begin
      @(negedge clk);
      if (t == 0 && !hold) in_valid = 1'b0;
      expect_at(w, t);
      if (inject && t == 2)         begin in_valid = 1'b1; in_word = ~w; end // R7 stall offer
      if (inject && t == TOTAL - 1) in_valid = 1'b0;
    end
  endtask

  initial begin
    #(20 * 20000);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    expect_idle("R1 reset");
    rst = 1'b0;
    @(negedge clk);
    expect_idle("R1 after reset");

    // Exhaustive word sweep: R3, R4, R5, R6 at every cycle
    for (int v = 0; v < (1 << W); v++) frame(W'(v), 1'b0, 1'b0);

    // R7: offers during a frame are ignored, no frame follows
    for (int v = 0; v < 2; v++) begin
      frame(W'(v == 0 ? 4'h9 : 4'h2), 1'b1, 1'b0);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        expect_idle("R7 no stray frame");
      end
    end

    // R6: back-to-back with valid held high
    frame(4'hA, 1'b0, 1'b1);
    frame(4'h5, 1'b0, 1'b1);
    frame(4'hC, 1'b0, 1'b0);

    // R1: reset in mid-frame
    in_valid = 1'b1;
    in_word  = 4'hF;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 8; k++) @(negedge clk);
    cmp("R1 pre-reset in frame", {cs_n, in_ready}, {1'b0, 1'b0});
    rst = 1'b1;
    @(negedge clk);
    expect_idle("R1 mid-frame reset");
    rst = 1'b0;
    @(negedge clk);
    expect_idle("R1 stays idle");
    frame(4'h6, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule